// File: doc/BRIEF.md
# Parity-Retransmission HARQ Receiver

This block is the receive half of a type-II hybrid ARQ link. The link uses two codes. A short cyclic check code covers every frame. A half-rate invertible code pairs the message D with a parity block P(D) of the same width. Each frame carries one block, either data or parity, followed by its check bits. The block checks the frame, and then does one of four things: it delivers the message at once, it rebuilds the message from a clean parity block by inversion, it combines the frame with the block held from an earlier attempt, or it keeps the frame for later. It answers each frame with exactly one acknowledge or negative-acknowledge pulse.

The transmitter reacts to each negative acknowledge by sending the other block type. The receiver holds one block at most. When joint decoding fails, the held block is replaced by the one just received, so the exchange can go on for any number of rounds until the message comes through.

Top module: `harq_parity_rx`

## Requirements
- R1: After reset, `ack`, `nak` and `msgValid` are low and no block is held.
- R2: A frame is `frameBits[11:4]` = block and `frameBits[3:0]` = check bits, where the check bits are the remainder of block·x^4 modulo x^4+x+1. A data frame (`frameIsParity`=0) whose whole 12-bit word has a zero remainder is delivered unchanged on `msgData`.
- R3: The parity block is P = D·(1+x+x^3) mod x^8+1, where bit i holds the coefficient of x^i. A clean parity frame delivers the unique D for which this holds.
- R4: A corrupted frame with no block held, or with a held block of the same type, is stored, and `nak` is pulsed.
- R5: A corrupted frame with a held block of the opposite type is decoded jointly with it. If the pair is consistent, or a single bit flip in D or in P makes it consistent, the corrected D is delivered.
- R6: If joint decoding fails, `nak` is pulsed and the held block becomes the block just received, with its type.
- R7: Every delivery empties the buffer, so a corrupted frame that follows a delivery is stored and is not paired.
- R8: Each accepted frame yields exactly one pulse on `ack` or on `nak`, one cycle wide, in the cycle after the frame. `msgValid` rises together with `ack` and only then.
- R9: Any number of failed rounds that alternate frame types may come before a successful joint decode.
- R10: While `frameValid` is low, the frame inputs have no effect on the outputs or on the held block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frameValid | input | 1 | A frame is present this cycle |
| frameIsParity | input | 1 | 1 = the frame holds the parity block, 0 = the frame holds data |
| frameBits | input | 12 | Block in the upper 8 bits, check bits in the lower 4 |
| msgValid | output | 1 | Recovered message valid (one cycle) |
| msgData | output | 8 | Recovered message |
| ack | output | 1 | Acknowledge pulse |
| nak | output | 1 | Negative-acknowledge pulse |

## Verification
Several rules are checked on every cycle by assertions. Each frame gets exactly one response, and no response appears without a frame. A delivery always coincides with an acknowledge and leaves the buffer empty. After a negative acknowledge, the buffer holds a block of the type just received. Whether a delivered value is correct cannot be seen that way. Correct inversion, correct single-bit repair on the data side and the parity side, correct rejection of heavier error patterns, and the replacement order over several rounds are shown only by the bench scenarios, against a model that finds the answers by exhaustive search.

// File: rtl/harq_rx_pkg.sv
package harq_rx_pkg;

  // Strobes from control to datapath for one accepted frame
  typedef struct packed {
    logic deliverRx;    // pass the received block out as the message
    logic deliverInv;   // pass the inverted parity block out
    logic deliverJoint; // pass the jointly corrected data out
    logic storeRx;      // keep the received block in the buffer
    logic clearBuf;     // empty the buffer
  } rxCtrl_t;

  // Remainder of a bit string, MSB first, divided by x^crcW + poly
  function automatic logic [31:0] crcRemainder(input logic [63:0] bits,
                                               input int nBits,
                                               input int crcW,
                                               input logic [31:0] poly);
    logic [31:0] r;
    logic fb;
    r = '0;
    for (int i = nBits - 1; i >= 0; i--) begin
      fb = r[crcW-1] ^ bits[i];
      r  = r << 1;
      if (fb) r = r ^ poly;
    end
    return r & ((32'd1 << crcW) - 32'd1);
  endfunction

  // Rotate left inside a k-bit ring
  function automatic logic [31:0] rotl(input logic [31:0] v, input int s, input int k);
    logic [31:0] m;
    logic [31:0] x;
    m = (32'd1 << k) - 32'd1;
    x = v & m;
    if (s == 0) return x;
    return ((x << s) | (x >> (k - s))) & m;
  endfunction

  // Product of two polynomials modulo x^k + 1
  function automatic logic [31:0] circMul(input logic [31:0] a, input logic [31:0] b, input int k);
    logic [31:0] acc;
    acc = '0;
    for (int i = 0; i < k; i++) begin
      if (a[i]) acc = acc ^ rotl(b, i, k);
    end
    return acc;
  endfunction

  // Inverse of gen modulo x^k + 1, found by search when elaborating
  function automatic logic [31:0] invPoly(input logic [31:0] gen, input int k);
    for (int c = 1; c < (1 << k); c++) begin
      if (circMul(32'(c), gen, k) == 32'd1) return 32'(c);
    end
    return '0;
  endfunction

endpackage

// File: rtl/harq_rx_datapath.sv
module harq_rx_datapath
  import harq_rx_pkg::*;
#(
  parameter int          BLK_W    = 8,
  parameter int          CHK_W    = 4,
  parameter logic [31:0] CHK_POLY = 32'h3,
  parameter logic [31:0] GEN_POLY = 32'h0B,
  localparam int         FRM_W    = BLK_W + CHK_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [FRM_W-1:0] frameBits,
  input  logic             frameIsParity,
  input  rxCtrl_t          ctrl,
  output logic             synZero,
  output logic             bufValid,
  output logic             bufIsParity,
  output logic             jointOk,
  output logic             msgValid,
  output logic [BLK_W-1:0] msgData
);

  localparam logic [BLK_W-1:0] GEN = GEN_POLY[BLK_W-1:0];
  localparam logic [BLK_W-1:0] INV = BLK_W'(invPoly(GEN_POLY, BLK_W));

  logic [BLK_W-1:0] bufBlk;
  logic [BLK_W-1:0] rxBlk;
  logic [BLK_W-1:0] dSel, pSel, syn;
  logic [BLK_W-1:0] matchD, matchP;
  logic [BLK_W-1:0] corrD, invD;

  assign rxBlk = frameBits[FRM_W-1 -: BLK_W];

  // Check-code syndrome over the whole frame
  always_comb begin
    synZero = (crcRemainder(64'(frameBits), FRM_W, CHK_W, CHK_POLY) == 32'd0);
  end

  // Joint decoding: data and parity taken from the frame or from the buffer
  assign dSel = frameIsParity ? bufBlk : rxBlk;
  assign pSel = frameIsParity ? rxBlk  : bufBlk;

  always_comb begin
    syn  = pSel ^ BLK_W'(circMul(32'(dSel), 32'(GEN), BLK_W));
    invD = BLK_W'(circMul(32'(rxBlk), 32'(INV), BLK_W));
  end

  // One syndrome pattern per single-bit error position
  for (genvar i = 0; i < BLK_W; i++) begin : g_errTable
    localparam logic [BLK_W-1:0] D_COL = BLK_W'(rotl(32'(GEN), i, BLK_W));
    localparam logic [BLK_W-1:0] P_COL = BLK_W'(1) << i;
    assign matchD[i] = (syn == D_COL);
    assign matchP[i] = (syn == P_COL);
  end

  assign corrD   = dSel ^ matchD;
  assign jointOk = (syn == '0) | (|matchD) | (|matchP);

  // Message output register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      msgValid <= 1'b0;
      msgData  <= '0;
    end else begin
      msgValid <= ctrl.deliverRx | ctrl.deliverInv | ctrl.deliverJoint;
      if (ctrl.deliverRx)         msgData <= rxBlk;
      else if (ctrl.deliverInv)   msgData <= invD;
      else if (ctrl.deliverJoint) msgData <= corrD;
    end
  end

  // Single-block retransmission buffer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufValid    <= 1'b0;
      bufIsParity <= 1'b0;
      bufBlk      <= '0;
    end else if (ctrl.storeRx) begin
      bufValid    <= 1'b1;
      bufIsParity <= frameIsParity;
      bufBlk      <= rxBlk;
    end else if (ctrl.clearBuf) begin
      bufValid    <= 1'b0;
    end
  end

  // R7
  delivered_clears_buf_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> !bufValid);

  // R6
  stored_block_matches_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctrl.storeRx) |-> (bufValid && bufBlk == $past(rxBlk)));

endmodule

// File: rtl/harq_rx_ctrl.sv
module harq_rx_ctrl
  import harq_rx_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    frameValid,
  input  logic    frameIsParity,
  input  logic    synZero,
  input  logic    bufValid,
  input  logic    bufIsParity,
  input  logic    jointOk,
  output rxCtrl_t ctrl,
  output logic    ack,
  output logic    nak
);

  logic pairable;
  logic ackNext, nakNext;

  assign pairable = bufValid && (bufIsParity != frameIsParity);

  always_comb begin
    ctrl    = '0;
    ackNext = 1'b0;
    nakNext = 1'b0;
    if (frameValid) begin
      if (synZero) begin
        ctrl.deliverRx  = !frameIsParity;
        ctrl.deliverInv = frameIsParity;
        ctrl.clearBuf   = 1'b1;
        ackNext         = 1'b1;
      end else if (pairable && jointOk) begin
        ctrl.deliverJoint = 1'b1;
        ctrl.clearBuf     = 1'b1;
        ackNext           = 1'b1;
      end else begin
        ctrl.storeRx = 1'b1;
        nakNext      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ack <= 1'b0;
      nak <= 1'b0;
    end else begin
      ack <= ackNext;
      nak <= nakNext;
    end
  end

  // R8
  one_response_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |=> (ack ^ nak));

  // R8
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ack || nak) |-> $past(frameValid));

  // R6
  nak_holds_latest_chk: assert property (@(posedge clk) disable iff (!rstN)
    nak |-> (bufValid && bufIsParity == $past(frameIsParity)));

  // R7
  ack_frees_buf_chk: assert property (@(posedge clk) disable iff (!rstN)
    ack |-> !bufValid);

endmodule

// File: rtl/harq_parity_rx.sv
module harq_parity_rx
  import harq_rx_pkg::*;
#(
  parameter int          BLK_W    = 8,
  parameter int          CHK_W    = 4,
  parameter logic [31:0] CHK_POLY = 32'h3,
  parameter logic [31:0] GEN_POLY = 32'h0B
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   frameValid,
  input  logic                   frameIsParity,
  input  logic [BLK_W+CHK_W-1:0] frameBits,
  output logic                   msgValid,
  output logic [BLK_W-1:0]       msgData,
  output logic                   ack,
  output logic                   nak
);

  rxCtrl_t ctrl;
  logic    synZero, bufValid, bufIsParity, jointOk;

  harq_rx_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .frameValid   (frameValid),
    .frameIsParity(frameIsParity),
    .synZero      (synZero),
    .bufValid     (bufValid),
    .bufIsParity  (bufIsParity),
    .jointOk      (jointOk),
    .ctrl         (ctrl),
    .ack          (ack),
    .nak          (nak)
  );

  harq_rx_datapath #(
    .BLK_W   (BLK_W),
    .CHK_W   (CHK_W),
    .CHK_POLY(CHK_POLY),
    .GEN_POLY(GEN_POLY)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .frameBits    (frameBits),
    .frameIsParity(frameIsParity),
    .ctrl         (ctrl),
    .synZero      (synZero),
    .bufValid     (bufValid),
    .bufIsParity  (bufIsParity),
    .jointOk      (jointOk),
    .msgValid     (msgValid),
    .msgData      (msgData)
  );

  // R8
  msg_with_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgValid == ack);

endmodule

// File: tb/tb_harq_parity_rx.sv
module tb_harq_parity_rx;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameValid = 1'b0;
  logic        frameIsParity = 1'b0;
  logic [11:0] frameBits = '0;
  logic        msgValid, ack, nak;
  logic [7:0]  msgData;

  int tests = 0, fails = 0, cycles = 0;
  bit started = 0, finished = 0;

  // Reference model state and expectations
  bit        mBufV = 0, mBufPar = 0, justAcked = 0;
  int        mBuf = 0, nakRun = 0;
  bit        eAck = 0, eNak = 0, eMv = 0;
  int        eMsg = 0;
  string     eTag = "R1";

  always #4 clk = ~clk;  // 125 MHz

  harq_parity_rx dut (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .frameIsParity(frameIsParity),
    .frameBits(frameBits), .msgValid(msgValid), .msgData(msgData), .ack(ack), .nak(nak)
  );

  // Long division by x^4+x+1 (binary 10011)
  function automatic int benchCrc(int val, int nBits);
    int v = val;
    for (int b = nBits - 1; b >= 4; b--)
      if (v[b]) v = v ^ (32'b10011 << (b - 4));
    return v & 15;
  endfunction

  function automatic logic [11:0] mkFrame(int blk);
    return 12'(((blk & 255) << 4) | benchCrc((blk & 255) << 4, 12));
  endfunction

  // D * (1+x+x^3) mod x^8+1
  function automatic int mulG(int a);
    int r = 0;
    int g = 'h0B;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        if (a[i] && g[j]) r = r ^ (1 << ((i + j) % 8));
    return r;
  endfunction

  function automatic int invP(int p);
    for (int c = 0; c < 256; c++) if (mulG(c) == p) return c;
    return -1;
  endfunction

  // Reference model: decides the response for the frame sampled at this edge
  always @(posedge clk) begin
    started = 1;
    if (!rstN) begin
      mBufV = 0; eAck = 0; eNak = 0; eMv = 0; eTag = "R1"; nakRun = 0; justAcked = 0;
    end else begin
      eAck = 0; eNak = 0; eMv = 0; eTag = "R10";
      if (frameValid) begin
        int blk;
        bit par;
        blk = int'(frameBits[11:4]);
        par = frameIsParity;
        if (benchCrc(int'(frameBits), 12) == 0) begin
          eAck = 1; eMv = 1;
          eMsg = par ? invP(blk) : blk;
          eTag = par ? "R3" : "R2";
          mBufV = 0; nakRun = 0;
        end else if (mBufV && mBufPar != par) begin
          int d, p, res;
          bit found;
          d = par ? mBuf : blk;
          p = par ? blk : mBuf;
          found = 0; res = 0;
          for (int e = 0; e < 17; e++) begin
            int dd, pp;
            dd = d ^ ((e >= 1 && e <= 8) ? (1 << (e - 1)) : 0);
            pp = p ^ ((e >= 9) ? (1 << (e - 9)) : 0);
            if (!found && mulG(dd) == pp) begin found = 1; res = dd; end
          end
          if (found) begin
            eAck = 1; eMv = 1; eMsg = res; mBufV = 0;
            eTag = (nakRun >= 2) ? "R9" : "R5";
            nakRun = 0;
          end else begin
            eNak = 1; mBuf = blk; mBufPar = par; mBufV = 1; eTag = "R6";
            nakRun++;
          end
        end else begin
          eNak = 1; eTag = justAcked ? "R7" : "R4";
          mBuf = blk; mBufPar = par; mBufV = 1;
          nakRun++;
        end
        justAcked = eAck;
      end
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    if (started && !finished) begin
      tests++;
      if (ack !== eAck || nak !== eNak || msgValid !== eMv || (eMv && msgData !== 8'(eMsg))) begin
        fails++;
        $display("FAIL %s: ack=%b nak=%b mv=%b msg=%h expected ack=%b nak=%b mv=%b msg=%h",
                 eTag, ack, nak, msgValid, msgData, eAck, eNak, eMv, 8'(eMsg));
      end
      if (eAck || eNak) begin
        // R8: single response, message valid tied to ack
        tests++;
        if ((ack && nak) || (ack !== msgValid)) begin
          fails++;
          $display("FAIL R8: ack=%b nak=%b mv=%b expected ack=%b nak=%b mv=%b",
                   ack, nak, msgValid, eAck, eNak, eAck);
        end
      end
    end
  end

  task automatic sendFrame(bit par, int blk, logic [11:0] flip);
    @(negedge clk);
    frameValid = 1; frameIsParity = par; frameBits = mkFrame(blk) ^ flip;
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      frameValid = 0; frameIsParity = 1'($urandom); frameBits = 12'($urandom);
    end
  endtask

  function automatic logic [11:0] blkBit(int i);
    return 12'(1) << (i + 4);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;                                    // R1 checked during reset
    idle(2);
    sendFrame(0, 'hA5, '0);                      // R2 clean data
    sendFrame(1, mulG('h3C), '0);                // R3 clean parity
    idle(1);
    sendFrame(0, 'h5A, blkBit(5));               // R4 stored
    sendFrame(1, mulG('h5A), 12'h002);           // R5 D error repaired
    sendFrame(1, mulG('h91), blkBit(3));         // R7 stored, not paired
    sendFrame(0, 'h91, 12'h001);                 // R5 P error repaired
    idle(2);
    sendFrame(0, 'h77, blkBit(0) | blkBit(1));   // R4
    sendFrame(1, mulG('h77), blkBit(6));         // R6 fails, parity kept
    sendFrame(0, 'h77, 12'h004);                 // R9 P error repaired
    sendFrame(0, 'h12, blkBit(2));               // R4
    sendFrame(0, 'h12, blkBit(7));               // R4 same type replaces
    idle(5);                                     // R10 garbage while idle
    sendFrame(1, mulG('h12), 12'h008);           // pairs with latest data
    for (int n = 0; n < 400; n++) begin
      logic [11:0] flip;
      int k;
      flip = '0;
      k = $urandom % 4;
      for (int j = 0; j < k; j++) flip = flip | (12'(1) << ($urandom % 12));
      if ($urandom % 3 == 0) flip = '0;
      begin
        int blk;
        bit par;
        blk = $urandom % 256;
        par = 1'($urandom);
        sendFrame(par, par ? mulG(blk) : blk, flip);
      end
      if ($urandom % 4 == 0) idle(1 + $urandom % 3);
    end
    idle(4);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule